// File: doc/BRIEF.md
# Shared-Address Read/Write Start Arbiter

This block sits in front of a burst memory whose read side and write side share one address bus. On every rising clock edge it samples two active-low port selects and the shared address, decides whether a read burst, a write burst or nothing starts on that edge, and latches the address into a read or a write address register.

A burst occupies two clock edges, so the same kind of operation may not start on two edges in a row. The arbiter remembers what it started on the previous edge. It refuses an illegal repeat. When both ports ask at once, it gives the edge to the operation that is allowed to start. When both selects are held active from idle, the starts alternate between read and write, and a read comes first.

Top module: `rw_start_arbiter`

## Requirements
- R1: After synchronous active-low reset (rst_n = 0 at an edge), both start strobes are 0, both address registers hold 0, and the previous-operation state is idle.
- R2: Selects are active low: rd_sel_n = 0 requests a read and wr_sel_n = 0 requests a write. They are sampled only on the rising clk edge, and the strobes are registered outputs valid for the cycle after that edge.
- R3: A read request on the edge immediately after a read start is ignored. No read start is produced and rd_addr keeps its value.
- R4: A write request on the edge immediately after a write start is ignored. No write start is produced and wr_addr keeps its value.
- R5: When both selects are active and nothing started on the previous edge, a read starts.
- R6: When both selects are active and a read started on the previous edge, a write starts. When a write started on the previous edge, a read starts.
- R7: Holding both selects active from idle gives strictly alternating starts R, W, R, W and so on, beginning with a read.
- R8: On every cycle at most one of rd_start and wr_start is 1.
- R9: The address is latched into rd_addr only on a read start and into wr_addr only on a write start. Otherwise each register holds its value.
- R10: With neither select active, no start occurs and the previous-operation state becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Positive clock; all sampling on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Read request, active low |
| wr_sel_n | input | 1 | Write request, active low |
| addr | input | ADDR_W | Shared address bus |
| rd_start | output | 1 | Read burst started on last edge |
| wr_start | output | 1 | Write burst started on last edge |
| rd_addr | output | ADDR_W | Read address register |
| wr_addr | output | ADDR_W | Write address register |

## Verification
The hardest case to reach is a request that arrives while the same kind of operation started one edge earlier, both alone and together with the other request. Either way, the previous-operation state decides the outcome. The stimulus reaches this case in three ways. It holds both selects low for long runs. It alternates a lone select with a pause of one edge. It also drives every select combination, with a changing address, from each of the three previous states in turn. A behavioural model in the bench predicts the strobes and both address registers on every clock.

// File: rtl/rw_arb_pkg.sv
// Package: shared types for the read/write start arbiter.
// Assumes: nothing; pure type definitions.
package rw_arb_pkg;
    // Kind of operation started on an edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_t;
endpackage

// File: rtl/rw_arb_decide.sv
// Module: combinational start decision.
// Does: turns the two requests and the previous operation into the
// operation to start now. A repeat of the previous operation is refused.
// A double request goes to the kind not just started, or to read from idle.
// Assumes: requests are already active-high.
module rw_arb_decide
    import rw_arb_pkg::*;
(
    input  logic     rd_req,
    input  logic     wr_req,
    input  op_kind_t prev_op,
    output op_kind_t next_op
);
    logic rd_ok;
    logic wr_ok;

    // Purpose: legal requests given the previous start.
    always_comb begin
        rd_ok = rd_req && (prev_op != OP_READ);
        wr_ok = wr_req && (prev_op != OP_WRITE);
    end

    // Purpose: pick one operation; read wins whenever both are legal.
    always_comb begin
        if (rd_ok)      next_op = OP_READ;
        else if (wr_ok) next_op = OP_WRITE;
        else            next_op = OP_IDLE;
    end
endmodule

// File: rtl/rw_arb_addr_reg.sv
// Module: address register loaded by a start strobe.
// Does: captures the shared address on a load edge and holds otherwise.
// Assumes: synchronous active-low reset to zero.
module rw_arb_addr_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Purpose: hold or capture the address.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rst_n) |=> $stable(q));
endmodule

// File: rtl/rw_start_arbiter.sv
// Module: top of the shared-address read/write start arbiter.
// Does: samples active-low selects on each rising edge and registers a
// read-start or write-start strobe. Loads the matching address register
// and remembers the started operation for the next decision.
// Assumes: one start per edge; bursts last two edges downstream.
module rw_start_arbiter
    import rw_arb_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_start,
    output logic              wr_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int NUM_PORTS = 2;

    op_kind_t prev_op;
    op_kind_t next_op;
    logic [NUM_PORTS-1:0] load_vec;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_q;

    rw_arb_decide u_decide (
        .rd_req  (!rd_sel_n),
        .wr_req  (!wr_sel_n),
        .prev_op (prev_op),
        .next_op (next_op)
    );

    // Purpose: per-port load strobes (index 0 read, 1 write).
    always_comb begin
        load_vec[0] = (next_op == OP_READ);
        load_vec[1] = (next_op == OP_WRITE);
    end

    // Purpose: remember the operation started on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_op <= OP_IDLE;
        else        prev_op <= next_op;
    end

    // Purpose: registered start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_start <= 1'b0;
            wr_start <= 1'b0;
        end else begin
            rd_start <= load_vec[0];
            wr_start <= load_vec[1];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_areg
        rw_arb_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_vec[p]),
            .d     (addr),
            .q     (addr_q[p])
        );
    end

    assign rd_addr = addr_q[0];
    assign wr_addr = addr_q[1];

    // R8
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_start, wr_start}));
    // R3
    no_rd_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);
    // R4
    no_wr_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
    // R6
    both_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !rd_sel_n && !wr_sel_n) |=> wr_start);
    // R6
    both_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !rd_sel_n && !wr_sel_n) |=> rd_start);
    // R10
    idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_n && wr_sel_n) |=> (!rd_start && !wr_start));
    // R9
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> (rd_addr == $past(addr)));
endmodule

// File: tb/rw_start_arbiter_test.sv
module rw_start_arbiter_test;
    localparam int AW = 18;
    logic clk = 1'b0;
    logic rst_n;
    logic rd_sel_n, wr_sel_n;
    logic [AW-1:0] addr;
    logic rd_start, wr_start;
    logic [AW-1:0] rd_addr, wr_addr;

    int checks = 0;
    int errors = 0;
    // model state: 0 idle, 1 read, 2 write
    int m_prev = 0;
    logic m_rs = 0, m_ws = 0;
    logic [AW-1:0] m_ra = '0, m_wa = '0;
    int seq_cnt = 0;

    always #2.5 clk = ~clk;

    rw_start_arbiter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .rd_start(rd_start), .wr_start(wr_start),
        .rd_addr(rd_addr), .wr_addr(wr_addr)
    );

    // Behavioural model updated at every edge from sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_rs = 0; m_ws = 0; m_ra = '0; m_wa = '0;
        end else begin
            bit rq, wq;
            rq = !rd_sel_n && m_prev != 1;
            wq = !wr_sel_n && m_prev != 2;
            m_rs = rq;
            m_ws = !rq && wq;
            if (m_rs) begin m_ra = addr; m_prev = 1; end
            else if (m_ws) begin m_wa = addr; m_prev = 2; end
            else m_prev = 0;
        end
    end

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs mid-cycle.
    always @(negedge clk) if (rst_n) begin
        chk("R2/R3/R5/R6 rd_start", rd_start, m_rs);
        chk("R2/R4/R5/R6 wr_start", wr_start, m_ws);
        chk("R9 rd_addr", rd_addr, m_ra);
        chk("R9 wr_addr", wr_addr, m_wa);
        chk("R8 onehot", {17'd0, rd_start & wr_start}, '0);
    end

    task automatic step(input logic r, input logic w);
        rd_sel_n = r; wr_sel_n = w; addr = AW'(seq_cnt * 37 + 5); seq_cnt++;
        @(posedge clk); #1;
    endtask

    initial begin
        fork
            begin
                #400000;
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        rst_n = 0; rd_sel_n = 1; wr_sel_n = 1; addr = '1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 rd_start", rd_start, 0);
        chk("R1 wr_start", wr_start, 0);
        chk("R1 rd_addr", rd_addr, 0);
        chk("R1 wr_addr", wr_addr, 0);
        rst_n = 1;
        // R7: both held from idle -> R,W,R,W
        step(0, 0);
        chk("R7 first is read", rd_start, 1);
        for (int i = 0; i < 20; i++) begin
            step(0, 0);
            chk("R7 alternation", rd_start, (i % 2 == 1));
        end
        step(1, 1);
        chk("R10 idle", {rd_start, wr_start}, 0);
        // R3 back-to-back reads
        step(0, 1); step(0, 1);
        chk("R3 second read ignored", rd_start, 0);
        step(1, 1);
        // R4 back-to-back writes
        step(1, 0); step(1, 0);
        chk("R4 second write ignored", wr_start, 0);
        step(1, 1);
        // R5/R6: all combos from each previous state
        for (int p = 0; p < 3; p++)
            for (int c = 0; c < 4; c++) begin
                step(1, 1);
                if (p == 1) step(0, 1);
                if (p == 2) step(1, 0);
                step(c[0], c[1]);
            end
        // long mixed runs
        for (int i = 0; i < 200; i++) step(((i * 7) % 5) < 2, ((i * 3) % 4) == 0);
        for (int i = 0; i < 50; i++) step(0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule